// File: doc/BRIEF.md
# Windowed Serial-Bus Slave Address Recognizer

This block decides whether a node on a two-wire serial bus (I2C or display data channel style) has to acknowledge the first byte after a START condition. A separate bit-level engine shifts in that byte. It presents the byte together with a one-cycle strobe, and this block answers in the same cycle with an acknowledge decision. It also keeps a registered record of the decision, which it holds until the bus sees a STOP or a repeated START. The record carries the transfer direction and marks a general-call match separately from a match on the node's own address.

Software programs an 8-bit address register. Bits 7..1 hold the node's 7-bit address, and bit 0 selects the expansion mode. The same register also supplies the calling address when the node works as a bus master: software loads it when it enters master mode and restores the slave address afterwards. The expansion bit changes the compare. Without it the address must match exactly. With it, only the top four address bits are compared, which gives a window of sixteen byte values, and the general-call address is accepted as well.

A small control register holds a module enable and an interrupt enable. The block also keeps four event flags: transmit, receive, arbitration-lost and no-acknowledge. They drive a single interrupt line under the one interrupt enable. Clearing the module enable silences the recognizer and returns every flag to its reset value.

Top module: `i2c_addr_window_match`

## Requirements
- R1: After reset the address register is 0xA0 with the expansion bit (bit 0) clear, and the control register is zero. So the block is disabled, the interrupt is low, and once enabled it accepts byte 0xA0.
- R2: With the expansion bit clear, an incoming byte matches only when its bits 7..1 equal address register bits 7..1. Incoming bit 0 (read/write) plays no part in the compare.
- R3: With the expansion bit set, an incoming byte matches when its bits 7..4 equal address register bits 7..4, whatever bits 3..0 are.
- R4: A byte whose bits 7..1 are all zero (general call) matches only while the expansion bit is set. `gen_call` goes high only for such a match.
- R5: `addr_ack` is high in the same cycle as `addr_stb` exactly when the block is enabled and the presented byte matches. It is low whenever `addr_stb` is low.
- R6: On the clock edge where `addr_stb` is high, `addr_hit` captures the match decision. It then holds until a clock edge with `bus_start` or `bus_stop` high, which clears it. On a clock edge where a bus event and the strobe coincide, the clear wins.
- R7: While the enable bit (control bit 0) is clear, nothing matches. `addr_hit`, `gen_call` and `xfer_read` clear on the next edge. All four event flags clear and cannot be set.
- R8: `irq` is high exactly when the interrupt enable (control bit 1) is set and at least one event flag is set. With the interrupt enable clear, all four flags are masked.
- R9: Flag i (0 transmit, 1 receive, 2 arbitration-lost, 3 no-acknowledge) is set by `evt_set[i]` and cleared by `evt_clr[i]`. When both are asserted on the same edge, the set wins. A flag keeps its value while the interrupt enable is toggled.
- R10: `xfer_read` captures incoming bit 0 on a matching strobe and is zero after a non-matching one.
- R11: Register writes use `reg_sel` 0 for the address register (all 8 bits) and 1 for the control register (bits 1..0). A new address value takes effect for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 the control register |
| reg_wdata | input | 8 | Register write data |
| addr_byte | input | 8 | First byte received after START |
| addr_stb | input | 1 | One-cycle strobe marking addr_byte valid |
| bus_start | input | 1 | START or repeated START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| evt_set | input | 4 | Per-flag set pulses (tx, rx, arb-lost, no-ack) |
| evt_clr | input | 4 | Per-flag clear pulses |
| addr_ack | output | 1 | Acknowledge decision during the strobe |
| addr_hit | output | 1 | Held result of the last address phase |
| gen_call | output | 1 | Held result was a general-call match |
| xfer_read | output | 1 | Held transfer direction of a match |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the edges of the window. These are bytes that share the top four bits with the stored address but differ below them, and the general-call byte when the stored window itself starts at zero. Uniformly random bytes almost never land there. The random stimulus therefore builds most bytes from the stored address with the low bits scrambled, and it injects the 0x00 and 0x01 bytes on purpose. Directed sequences cover the corners that random traffic cannot reach: a strobe that coincides with a bus event, a disable while a match is being held, and a flag set and cleared on the same edge.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

   localparam int unsigned NUM_FLAGS = 4;

   typedef enum logic [1:0] {
      FLG_TX  = 2'd0,
      FLG_RX  = 2'd1,
      FLG_ARB = 2'd2,
      FLG_NAK = 2'd3
   } flag_idx_e;

   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_CTRL = 1'b1
   } reg_sel_e;

   localparam int unsigned CTRL_EN_BIT = 0;
   localparam int unsigned CTRL_IE_BIT = 1;

   typedef struct packed {
      logic irq_en;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
   import addrwin_pkg::*;
#(
   parameter int unsigned        BYTE_W     = 8,
   parameter logic [BYTE_W-1:0]  RESET_ADDR = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-2:0] stored_addr,
   output logic              ext_mode,
   output ctrl_t             ctrl
);
   localparam int unsigned ADDR_W = BYTE_W - 1;

   logic [BYTE_W-1:0] addr_q;
   ctrl_t             ctrl_q;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("addrwin_regs: BYTE_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= RESET_ADDR;
      end else if (wr_en && (wr_sel == SEL_ADDR)) begin
         addr_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && (wr_sel == SEL_CTRL)) begin
         ctrl_q.enable <= wr_data[CTRL_EN_BIT];
         ctrl_q.irq_en <= wr_data[CTRL_IE_BIT];
      end
   end

   assign stored_addr = addr_q[BYTE_W-1 -: ADDR_W];
   assign ext_mode    = addr_q[0];
   assign ctrl        = ctrl_q;

   AST_ADDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_ADDR) |=> ({stored_addr, ext_mode} == $past(wr_data))); // R11

   AST_CTRL_KEEPS_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_CTRL) |=> $stable(ctrl)); // R11

endmodule

// File: rtl/addrwin_cmp.sv
module addrwin_cmp #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned WIN_BITS  = 4,
   parameter bit          GC_ENABLE = 1'b1
) (
   input  logic [ADDR_W-1:0] stored_addr,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] rx_addr,
   output logic              hit,
   output logic              gcall
);
   localparam int unsigned LOW_BITS = ADDR_W - WIN_BITS;

   logic [ADDR_W-1:0] bit_ok;
   logic              own_hit;
   logic              gc_hit;

   generate
      if (WIN_BITS < 1 || WIN_BITS > ADDR_W) begin : g_bad_win
         $error("addrwin_cmp: WIN_BITS must lie in 1..ADDR_W");
      end

      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         if (i >= LOW_BITS) begin : g_always
            assign bit_ok[i] = (stored_addr[i] == rx_addr[i]);
         end else begin : g_masked
            assign bit_ok[i] = ext_mode | (stored_addr[i] == rx_addr[i]);
         end
      end

      if (GC_ENABLE) begin : g_gc
         assign gc_hit = ext_mode & (rx_addr == '0);
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate

   assign own_hit = &bit_ok;
   assign hit     = own_hit | gc_hit;
   assign gcall   = gc_hit;

   always_comb begin
      if (gcall) begin
         AST_GC_ONLY_EXT: assert (ext_mode && hit); // R4
      end
   end

endmodule

// File: rtl/addrwin_session.sv
module addrwin_session (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic stb,
   input  logic bus_start,
   input  logic bus_stop,
   input  logic hit_in,
   input  logic gc_in,
   input  logic dir_in,
   output logic hit_q,
   output logic gc_q,
   output logic dir_q
);
   logic clear_now;

   assign clear_now = !enable || bus_start || bus_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         gc_q  <= 1'b0;
         dir_q <= 1'b0;
      end else if (clear_now) begin
         hit_q <= 1'b0;
         gc_q  <= 1'b0;
         dir_q <= 1'b0;
      end else if (stb) begin
         hit_q <= hit_in;
         gc_q  <= hit_in & gc_in;
         dir_q <= hit_in & dir_in;
      end
   end

   AST_EVENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start || bus_stop) |=> !hit_q && !gc_q && !dir_q); // R6

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !stb && !bus_start && !bus_stop) |=> $stable(hit_q) && $stable(gc_q)); // R6

   AST_GC_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      gc_q |-> hit_q); // R4

   AST_DIR_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q |-> hit_q); // R10

endmodule

// File: rtl/addrwin_irq.sv
module addrwin_irq #(
   parameter int unsigned NFLAGS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              irq_en,
   input  logic [NFLAGS-1:0] set_i,
   input  logic [NFLAGS-1:0] clr_i,
   output logic [NFLAGS-1:0] flags,
   output logic              irq
);
   generate
      if (NFLAGS < 1) begin : g_bad_flags
         $error("addrwin_irq: NFLAGS must be at least 1");
      end
      for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[f] <= 1'b0;
            end else if (!enable) begin
               flags[f] <= 1'b0;
            end else if (set_i[f]) begin
               flags[f] <= 1'b1;
            end else if (clr_i[f]) begin
               flags[f] <= 1'b0;
            end
         end
      end
   endgenerate

   assign irq = irq_en & (|flags);

   AST_FLAGS_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (flags == '0)); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && set_i[0] && clr_i[0]) |=> flags[0]); // R9

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R8

endmodule

// File: rtl/i2c_addr_window_match.sv
module i2c_addr_window_match
   import addrwin_pkg::*;
#(
   parameter int unsigned        BYTE_W     = 8,
   parameter int unsigned        WIN_BITS   = 4,
   parameter bit                 GC_ENABLE  = 1'b1,
   parameter logic [BYTE_W-1:0]  RESET_ADDR = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic [BYTE_W-1:0] addr_byte,
   input  logic              addr_stb,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [NUM_FLAGS-1:0] evt_set,
   input  logic [NUM_FLAGS-1:0] evt_clr,
   output logic              addr_ack,
   output logic              addr_hit,
   output logic              gen_call,
   output logic              xfer_read,
   output logic              irq
);
   localparam int unsigned ADDR_W = BYTE_W - 1;

   logic [ADDR_W-1:0]    stored_addr;
   logic                 ext_mode;
   ctrl_t                ctrl;
   logic                 cmp_hit;
   logic                 cmp_gc;
   logic [NUM_FLAGS-1:0] flags;

   addrwin_regs #(
      .BYTE_W     (BYTE_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr),
      .wr_sel      (reg_sel),
      .wr_data     (reg_wdata),
      .stored_addr (stored_addr),
      .ext_mode    (ext_mode),
      .ctrl        (ctrl)
   );

   addrwin_cmp #(
      .ADDR_W    (ADDR_W),
      .WIN_BITS  (WIN_BITS),
      .GC_ENABLE (GC_ENABLE)
   ) u_cmp (
      .stored_addr (stored_addr),
      .ext_mode    (ext_mode),
      .rx_addr     (addr_byte[BYTE_W-1:1]),
      .hit         (cmp_hit),
      .gcall       (cmp_gc)
   );

   addrwin_session u_session (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (ctrl.enable),
      .stb       (addr_stb),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .hit_in    (cmp_hit),
      .gc_in     (cmp_gc),
      .dir_in    (addr_byte[0]),
      .hit_q     (addr_hit),
      .gc_q      (gen_call),
      .dir_q     (xfer_read)
   );

   addrwin_irq #(
      .NFLAGS (NUM_FLAGS)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ctrl.enable),
      .irq_en (ctrl.irq_en),
      .set_i  (evt_set),
      .clr_i  (evt_clr),
      .flags  (flags),
      .irq    (irq)
   );

   assign addr_ack = addr_stb & ctrl.enable & cmp_hit;

   AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_stb |-> !addr_ack); // R5

   AST_ACK_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ack && !bus_start && !bus_stop) |=> addr_hit); // R6

   AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.enable |-> !addr_ack); // R7

   AST_DISABLED_DROPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.enable |=> !addr_hit && !gen_call); // R7

endmodule

// File: tb/i2c_addr_window_match_bench.sv
module i2c_addr_window_match_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] addr_byte = '0;
   logic       addr_stb = 1'b0;
   logic       bus_start = 1'b0;
   logic       bus_stop = 1'b0;
   logic [3:0] evt_set = '0;
   logic [3:0] evt_clr = '0;
   logic       addr_ack, addr_hit, gen_call, xfer_read, irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] mdl_addr = 8'hA0;
   logic       mdl_en = 1'b0;

   always #10 clk = ~clk;

   i2c_addr_window_match u_i2c_addr_window_match (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .addr_byte(addr_byte), .addr_stb(addr_stb),
      .bus_start(bus_start), .bus_stop(bus_stop), .evt_set(evt_set),
      .evt_clr(evt_clr), .addr_ack(addr_ack), .addr_hit(addr_hit),
      .gen_call(gen_call), .xfer_read(xfer_read), .irq(irq)
   );

   function automatic logic exp_match(input logic [7:0] a, input logic [7:0] b, input logic en);
      if (!en) return 1'b0;
      if (a[0]) return (b[7:4] == a[7:4]) || (b[7:1] == 7'd0);
      return b[7:1] == a[7:1];
   endfunction

   function automatic logic exp_gc(input logic [7:0] a, input logic [7:0] b, input logic en);
      return en && a[0] && (b[7:1] == 7'd0);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (sel == 1'b0) mdl_addr = d; else mdl_en = d[0];
   endtask

   task automatic pulse_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   // strobe one byte, check the same-cycle ack and the captured result
   task automatic send(input logic [7:0] b, input string req);
      logic m, g;
      m = exp_match(mdl_addr, b, mdl_en);
      g = exp_gc(mdl_addr, b, mdl_en);
      @(negedge clk);
      addr_byte = b; addr_stb = 1'b1;
      #1 chk({req, " R5 ack"}, {7'd0, addr_ack}, {7'd0, m});
      @(negedge clk);
      addr_stb = 1'b0;
      chk({req, " R6 hit"}, {7'd0, addr_hit}, {7'd0, m});
      chk({req, " R4 gen_call"}, {7'd0, gen_call}, {7'd0, g});
      chk({req, " R10 dir"}, {7'd0, xfer_read}, {7'd0, m & b[0]});
   endtask

   initial begin
      #(200000 * 20);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] a, b;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq at reset", {7'd0, irq}, 8'd0);
      chk("R1 hit at reset", {7'd0, addr_hit}, 8'd0);
      send(8'hA0, "R1 disabled after reset");
      wr_reg(1'b1, 8'h01);
      send(8'hA0, "R1 reset address");
      pulse_stop();
      send(8'hA1, "R2 rw bit ignored");
      pulse_stop();
      send(8'hA2, "R2 neighbour rejected");
      send(8'h00, "R4 gc without ext");

      // R3/R4 window mode
      wr_reg(1'b0, 8'hA1);
      send(8'hAF, "R3 window top");
      pulse_stop();
      send(8'hB0, "R3 outside window");
      send(8'h01, "R4 gc read");
      pulse_stop();
      send(8'h00, "R4 gc in window");
      pulse_stop();

      // R6 hold and clear by repeated start; event beats strobe
      send(8'hA4, "R6 hold setup");
      repeat (4) @(negedge clk);
      chk("R6 held", {7'd0, addr_hit}, 8'd1);
      bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
      chk("R6 start clears", {7'd0, addr_hit}, 8'd0);
      @(negedge clk);
      addr_byte = 8'hA4; addr_stb = 1'b1; bus_stop = 1'b1;
      @(negedge clk);
      addr_stb = 1'b0; bus_stop = 1'b0;
      chk("R6 event wins over strobe", {7'd0, addr_hit}, 8'd0);

      // R7 disable while holding a match
      send(8'hA5, "R7 setup");
      wr_reg(1'b1, 8'h00);
      @(negedge clk);
      chk("R7 hit dropped", {7'd0, addr_hit}, 8'd0);
      send(8'hA5, "R7 disabled no match");

      // R8/R9 flags and interrupt
      wr_reg(1'b1, 8'h03);
      mdl_en = 1'b1;
      @(negedge clk); evt_set = 4'b0100;
      @(negedge clk); evt_set = 4'b0000;
      chk("R9 arb flag raises irq", {7'd0, irq}, 8'd1);
      wr_reg(1'b1, 8'h01);
      chk("R8 masked", {7'd0, irq}, 8'd0);
      wr_reg(1'b1, 8'h03);
      chk("R9 flag kept across mask", {7'd0, irq}, 8'd1);
      @(negedge clk); evt_clr = 4'b0100;
      @(negedge clk); evt_clr = 4'b0000;
      chk("R9 clear", {7'd0, irq}, 8'd0);
      for (int f = 0; f < 4; f++) begin
         @(negedge clk); evt_set = 4'(1 << f); evt_clr = 4'(1 << f);
         @(negedge clk); evt_set = '0; evt_clr = '0;
         chk("R9 set wins", {7'd0, irq}, 8'd1);
         @(negedge clk); evt_clr = 4'(1 << f);
         @(negedge clk); evt_clr = '0;
         chk("R9 cleared", {7'd0, irq}, 8'd0);
      end
      @(negedge clk); evt_set = 4'b1000;
      @(negedge clk); evt_set = '0;
      wr_reg(1'b1, 8'h02);
      wr_reg(1'b1, 8'h03);
      chk("R7 flags cleared by disable", {7'd0, irq}, 8'd0);
      wr_reg(1'b1, 8'h02);
      @(negedge clk); evt_set = 4'b0001;
      @(negedge clk); evt_set = '0;
      chk("R7 no set while disabled", {7'd0, irq}, 8'd0);

      // R11 plus random windows and exact addresses
      for (int n = 0; n < 400; n++) begin
         a = 8'($urandom);
         wr_reg(1'b0, a);
         wr_reg(1'b1, ($urandom % 10 != 0) ? 8'h01 : 8'h00);
         case ($urandom % 5)
            0: b = 8'($urandom);
            1: b = {a[7:4], 4'($urandom)};
            2: b = {a[7:1], 1'($urandom)};
            3: b = {7'd0, 1'($urandom)};
            default: b = a ^ 8'(1 << ($urandom % 8));
         endcase
         send(b, "R11 random R2 R3");
         pulse_stop();
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule